// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges four receive- and transmit-side interrupt sources of a 550-style UART into one interrupt request line and a 4-bit identification code. The four sources are receive line errors, receive FIFO fill level, receive idle timeout and transmit holding-empty. The surrounding UART supplies the source enables, the receive trigger-level selection, the current occupancy of both FIFOs and single-cycle pulses. The pulses mark line errors, status-register reads, identification reads, receive data reads, receive FIFO pushes, holding-register writes and character-time ticks. The block owns the priority order, the clearing rules, the idle timeout and the start-up delay on the holding-empty source.

Software reads the identification code to find the highest-priority pending cause. While that read is in progress, the code is held steady. Any event that arises during the read is kept and shows on the next read. The holding-empty source is delayed by one character time after the transmit FIFO drains, unless that FIFO held two or more characters since the previous empty event. This keeps a start-up burst of interrupts away from a CPU that is still filling the FIFO.

Top module: `uart_irq_ident`

## Requirements
- R1: `iid_o` takes only these codes: 4'b0001 for nothing pending, 4'b0110 for line error, 4'b0100 for receive data, 4'b1100 for timeout and 4'b0010 for holding empty. `irq_o` is high exactly when `iid_o[0]` is 0. The code reflects the pending sources of the previous cycle.
- R2: When several sources are pending, the code reports the highest one in this order: line error, receive data, timeout, holding empty.
- R3: Receive data is pending while `rx_count_i` is at or above the trigger level. `trig_sel_i` 00, 01, 10 and 11 select 1, 4, 8 and 14 characters. The source drops as soon as the count falls below the level.
- R4: A `line_err_i` pulse sets the line-error source and an `lsr_rd_i` pulse clears it. If both arrive in the same cycle, the error is kept.
- R5: The timeout source becomes pending after 4 `char_tick_i` pulses in which the receive FIFO is non-empty and sees no push or read. A push or a read restarts the count and removes the timeout. An empty FIFO never times out.
- R6: `en_i[0]` gates receive data and timeout, `en_i[1]` gates holding empty and `en_i[2]` gates line error. A gated source keeps its state and shows once it is enabled again.
- R7: If the transmit FIFO count reached 2 or more since the previous empty event, holding empty becomes pending in the cycle after the count drops to 0.
- R8: Otherwise holding empty becomes pending at the first `char_tick_i` after the count drops to 0.
- R9: Holding empty is cleared by `thr_wr_i`, by a non-zero transmit count, or by `iir_rd_i` while the code shows 4'b0010. An identification read that shows another code leaves it pending.
- R10: During an `iir_rd_i` cycle the code does not change. A source that arises in that cycle appears in the code afterwards.
- R11: Reset gives code 4'b0001 with `irq_o` low. After reset, holding empty stays clear until the transmit FIFO has been filled and drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 3 | Source enables: bit0 data/timeout, bit1 holding empty, bit2 line error |
| trig_sel_i | input | 2 | Receive trigger-level selection |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| line_err_i | input | 1 | Pulse: overrun, parity, framing or break error seen |
| lsr_rd_i | input | 1 | Pulse: line status register read |
| iir_rd_i | input | 1 | Pulse: identification code read |
| rbr_rd_i | input | 1 | Pulse: receive data read |
| rx_push_i | input | 1 | Pulse: character written into receive FIFO |
| thr_wr_i | input | 1 | Pulse: holding register write |
| char_tick_i | input | 1 | Pulse: one character time elapsed |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 4 | Identification code |

## Verification
The hardest situations to reach are the ones where time and history decide the code rather than the present inputs. The timeout needs an exact count of quiet character ticks with data waiting. Holding empty depends on the peak fill level since the last empty event. The stimulus table walks a continuous history for these cases: it raises the transmit count to two and drains it, then refills it only to one, and it spaces ticks one per step around pushes and reads. Directed steps then put a line error in the same cycle as an identification read, to check that the code stays frozen while the error is kept and the holding-empty source is cleared by that same read.

// File: rtl/irqid_pkg.sv
package irqid_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_LINE = 4'b0110,
    IID_DATA = 4'b0100,
    IID_TOUT = 4'b1100,
    IID_TXE  = 4'b0010
  } iid_e;

  // receive fill threshold for a trigger selection code
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/irq_rx_src.sv
module irq_rx_src #(
  parameter int CNT_W    = 5,
  parameter int TO_TICKS = 4,
  localparam int TO_W    = $clog2(TO_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_err_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             rx_push_i,
  input  logic             char_tick_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             line_raw_o,
  output logic             data_raw_o,
  output logic             tout_raw_o
);
  import irqid_pkg::*;

  logic            line_q, line_d, line_en;
  logic [TO_W-1:0] idle_q, idle_d;
  logic            idle_en;
  logic            rx_empty, rx_act, idle_sat;

  assign rx_empty = (rx_count_i == '0);
  assign rx_act   = rbr_rd_i | rx_push_i;
  assign idle_sat = (idle_q == TO_W'(TO_TICKS));

  always_comb begin
    line_en = line_err_i | lsr_rd_i;
    line_d  = line_err_i;              // set wins over a clearing read
    idle_en = rx_empty | rx_act | (char_tick_i & ~idle_sat);
    idle_d  = (rx_empty | rx_act) ? '0 : idle_q + TO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      idle_q <= '0;
    end else begin
      if (line_en) line_q <= line_d;
      if (idle_en) idle_q <= idle_d;
    end
  end

  assign line_raw_o = line_q;
  assign data_raw_o = (32'(rx_count_i) >= trig_level(trig_sel_i));
  assign tout_raw_o = idle_sat & ~rx_empty;

endmodule

// File: rtl/irq_txe_track.sv
module irq_txe_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             thr_wr_i,
  input  logic             char_tick_i,
  input  logic             rd_clr_i,
  output logic             txe_raw_o
);

  logic tx_empty, empty_rise;
  logic empty_d_q;
  logic two_q, two_d, two_en;
  logic txe_q, txe_d;
  logic dly_q, dly_d;

  assign tx_empty   = (tx_count_i == '0);
  assign empty_rise = tx_empty & ~empty_d_q;

  always_comb begin
    two_en = empty_rise | (tx_count_i >= CNT_W'(2));
    two_d  = ~empty_rise;
    txe_d  = txe_q;
    dly_d  = dly_q;
    if (thr_wr_i || !tx_empty || rd_clr_i) begin
      txe_d = 1'b0;
      dly_d = 1'b0;
    end else if (empty_rise) begin
      txe_d = two_q;
      dly_d = ~two_q;
    end else if (dly_q && char_tick_i) begin
      txe_d = 1'b1;
      dly_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_d_q <= 1'b1;
      two_q     <= 1'b0;
      txe_q     <= 1'b0;
      dly_q     <= 1'b0;
    end else begin
      empty_d_q <= tx_empty;
      if (two_en) two_q <= two_d;
      txe_q <= txe_d;
      dly_q <= dly_d;
    end
  end

  assign txe_raw_o = txe_q;

endmodule

// File: rtl/irq_prio_code.sv
module irq_prio_code (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_p_i,
  input  logic       data_p_i,
  input  logic       tout_p_i,
  input  logic       txe_p_i,
  input  logic       id_rd_i,
  output logic [3:0] iid_o,
  output logic       irq_o,
  output logic       txe_rd_clr_o
);
  import irqid_pkg::*;

  iid_e code_q, code_d;

  always_comb begin
    if (line_p_i)      code_d = IID_LINE;
    else if (data_p_i) code_d = IID_DATA;
    else if (tout_p_i) code_d = IID_TOUT;
    else if (txe_p_i)  code_d = IID_TXE;
    else               code_d = IID_NONE;
  end

  // hold the reported code while it is being read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= IID_NONE;
    else if (!id_rd_i) code_q <= code_d;
  end

  assign iid_o        = code_q;
  assign irq_o        = ~code_q[0];
  assign txe_rd_clr_o = id_rd_i & (code_q == IID_TXE);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int  FIFO_DEPTH    = 16,
  parameter int  TIMEOUT_TICKS = 4,
  localparam int CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             line_err_i,
  input  logic             lsr_rd_i,
  input  logic             iir_rd_i,
  input  logic             rbr_rd_i,
  input  logic             rx_push_i,
  input  logic             thr_wr_i,
  input  logic             char_tick_i,
  output logic             irq_o,
  output logic [3:0]       iid_o
);

  logic [1:0] rst_pipe;
  logic       rst_ni;
  logic       line_raw, data_raw, tout_raw, txe_raw;
  logic       line_pend, data_pend, tout_pend, txe_pend;
  logic       txe_rd_clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  irq_rx_src #(.CNT_W(CNT_W), .TO_TICKS(TIMEOUT_TICKS)) u_rx_src (
    .clk(clk), .rst_n(rst_ni),
    .line_err_i(line_err_i), .lsr_rd_i(lsr_rd_i),
    .rbr_rd_i(rbr_rd_i), .rx_push_i(rx_push_i),
    .char_tick_i(char_tick_i), .trig_sel_i(trig_sel_i),
    .rx_count_i(rx_count_i),
    .line_raw_o(line_raw), .data_raw_o(data_raw), .tout_raw_o(tout_raw)
  );

  irq_txe_track #(.CNT_W(CNT_W)) u_txe (
    .clk(clk), .rst_n(rst_ni),
    .tx_count_i(tx_count_i), .thr_wr_i(thr_wr_i),
    .char_tick_i(char_tick_i), .rd_clr_i(txe_rd_clr),
    .txe_raw_o(txe_raw)
  );

  always_comb begin
    line_pend = line_raw & en_i[2];
    data_pend = data_raw & en_i[0];
    tout_pend = tout_raw & en_i[0];
    txe_pend  = txe_raw  & en_i[1];
  end

  irq_prio_code u_prio (
    .clk(clk), .rst_n(rst_ni),
    .line_p_i(line_pend), .data_p_i(data_pend),
    .tout_p_i(tout_pend), .txe_p_i(txe_pend),
    .id_rd_i(iir_rd_i),
    .iid_o(iid_o), .irq_o(irq_o), .txe_rd_clr_o(txe_rd_clr)
  );

endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iir_rd_i,
  input logic       thr_wr_i,
  input logic [3:0] iid_o,
  input logic       irq_o,
  input logic       line_pend,
  input logic       data_pend,
  input logic       tout_pend,
  input logic       txe_pend,
  input logic       txe_raw
);

  // R1: nothing pending yields the idle code and a low request
  a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pend && !data_pend && !tout_pend && !txe_pend && !iir_rd_i)
    |=> (iid_o == 4'b0001 && !irq_o));

  // R2: line error outranks every other source
  a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pend && !iir_rd_i) |=> (iid_o == 4'b0110));

  // R2: receive data outranks timeout and holding empty
  a_r2_data_second: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pend && data_pend && !iir_rd_i) |=> (iid_o == 4'b0100));

  // R9: a holding-register write clears holding empty
  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_i |=> !txe_raw);

  // R10: the code is frozen across an identification read
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd_i |=> $stable(iid_o));

endmodule

bind uart_irq_ident irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_ni),
  .iir_rd_i(iir_rd_i), .thr_wr_i(thr_wr_i),
  .iid_o(iid_o), .irq_o(irq_o),
  .line_pend(line_pend), .data_pend(data_pend),
  .tout_pend(tout_pend), .txe_pend(txe_pend),
  .txe_raw(txe_raw)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;

  logic       clk;
  logic       rst_n;
  logic [2:0] en;
  logic [1:0] trig;
  logic [4:0] rxc, txc;
  logic       lerr, lsr, iir, rbr, push, thrw, tick;
  logic       irq;
  logic [3:0] iid;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .en_i(en), .trig_sel_i(trig),
    .rx_count_i(rxc), .tx_count_i(txc),
    .line_err_i(lerr), .lsr_rd_i(lsr), .iir_rd_i(iir),
    .rbr_rd_i(rbr), .rx_push_i(push), .thr_wr_i(thrw),
    .char_tick_i(tick), .irq_o(irq), .iid_o(iid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {req, en, trig, rx, tx, pulses(lerr lsr iir rbr push thrw tick), expected code}
  localparam logic [29:0] VEC [0:NV-1] = '{
    {4'd11, 3'b111, 2'b00, 5'd0,  5'd0, 7'b0000000, 4'b0001}, // R11 no holding empty after reset
    {4'd3,  3'b111, 2'b00, 5'd1,  5'd0, 7'b0000100, 4'b0100}, // R3 level 1 reached
    {4'd3,  3'b111, 2'b01, 5'd3,  5'd0, 7'b0000100, 4'b0001}, // R3 below 4
    {4'd3,  3'b111, 2'b01, 5'd4,  5'd0, 7'b0000100, 4'b0100}, // R3 at 4
    {4'd3,  3'b111, 2'b11, 5'd13, 5'd0, 7'b0000100, 4'b0001}, // R3 below 14
    {4'd3,  3'b111, 2'b11, 5'd14, 5'd0, 7'b0000100, 4'b0100}, // R3 at 14
    {4'd3,  3'b111, 2'b10, 5'd8,  5'd0, 7'b0000000, 4'b0100}, // R3 at 8
    {4'd3,  3'b111, 2'b10, 5'd7,  5'd0, 7'b0001000, 4'b0001}, // R3 drops below 8
    {4'd2,  3'b111, 2'b10, 5'd8,  5'd0, 7'b1000100, 4'b0110}, // R2 line over data
    {4'd4,  3'b111, 2'b10, 5'd8,  5'd0, 7'b0100000, 4'b0100}, // R4 status read clears
    {4'd6,  3'b011, 2'b10, 5'd8,  5'd0, 7'b1000000, 4'b0100}, // R6 line gated
    {4'd6,  3'b111, 2'b10, 5'd8,  5'd0, 7'b0000000, 4'b0110}, // R6 held error shows
    {4'd4,  3'b111, 2'b10, 5'd8,  5'd0, 7'b0100000, 4'b0100}, // R4 clear again
    {4'd6,  3'b110, 2'b10, 5'd8,  5'd0, 7'b0000000, 4'b0001}, // R6 data gated
    {4'd3,  3'b111, 2'b10, 5'd0,  5'd0, 7'b0001000, 4'b0001}, // R3 drained
    {4'd7,  3'b111, 2'b10, 5'd0,  5'd1, 7'b0000010, 4'b0001}, // R7 fill one
    {4'd7,  3'b111, 2'b10, 5'd0,  5'd2, 7'b0000010, 4'b0001}, // R7 fill two
    {4'd7,  3'b111, 2'b10, 5'd0,  5'd0, 7'b0000000, 4'b0010}, // R7 immediate empty
    {4'd9,  3'b111, 2'b10, 5'd0,  5'd1, 7'b0000010, 4'b0001}, // R9 write clears
    {4'd8,  3'b111, 2'b10, 5'd0,  5'd0, 7'b0000000, 4'b0001}, // R8 delayed
    {4'd8,  3'b111, 2'b10, 5'd0,  5'd0, 7'b0000001, 4'b0010}, // R8 tick releases
    {4'd6,  3'b101, 2'b10, 5'd0,  5'd0, 7'b0000000, 4'b0001}, // R6 empty gated
    {4'd6,  3'b111, 2'b10, 5'd0,  5'd0, 7'b0000000, 4'b0010}, // R6 re-enabled
    {4'd2,  3'b111, 2'b00, 5'd1,  5'd0, 7'b0000100, 4'b0100}, // R2 data over empty
    {4'd2,  3'b111, 2'b00, 5'd0,  5'd0, 7'b0001000, 4'b0010}, // R2 empty returns
    {4'd5,  3'b111, 2'b01, 5'd2,  5'd0, 7'b0000100, 4'b0010}, // R5 push, count restarts
    {4'd5,  3'b111, 2'b01, 5'd2,  5'd0, 7'b0000001, 4'b0010}, // R5 tick 1
    {4'd5,  3'b111, 2'b01, 5'd2,  5'd0, 7'b0000001, 4'b0010}, // R5 tick 2
    {4'd5,  3'b111, 2'b01, 5'd2,  5'd0, 7'b0000001, 4'b0010}, // R5 tick 3
    {4'd5,  3'b111, 2'b01, 5'd2,  5'd0, 7'b0000001, 4'b1100}, // R5 tick 4 timeout
    {4'd5,  3'b111, 2'b01, 5'd3,  5'd0, 7'b0000100, 4'b0010}, // R5 push clears
    {4'd5,  3'b111, 2'b01, 5'd3,  5'd0, 7'b0000001, 4'b0010}, // R5 tick 1
    {4'd5,  3'b111, 2'b01, 5'd3,  5'd0, 7'b0000001, 4'b0010}, // R5 tick 2
    {4'd5,  3'b111, 2'b01, 5'd3,  5'd0, 7'b0000001, 4'b0010}, // R5 tick 3
    {4'd5,  3'b111, 2'b01, 5'd3,  5'd0, 7'b0000001, 4'b1100}, // R5 tick 4 timeout
    {4'd5,  3'b111, 2'b01, 5'd0,  5'd0, 7'b0001000, 4'b0010}, // R5 read to empty clears
    {4'd5,  3'b111, 2'b01, 5'd0,  5'd0, 7'b0000001, 4'b0010}, // R5 empty never times out
    {4'd5,  3'b111, 2'b01, 5'd0,  5'd0, 7'b0000001, 4'b0010},
    {4'd5,  3'b111, 2'b01, 5'd0,  5'd0, 7'b0000001, 4'b0010},
    {4'd5,  3'b111, 2'b01, 5'd0,  5'd0, 7'b0000001, 4'b0010}
  };

  task automatic check(input logic [3:0] exp, input int req);
    n_checks++;
    if (iid !== exp || irq !== ~exp[0]) begin
      n_err++;
      $display("FAIL R%0d: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp, ~exp[0]);
    end
  endtask

  task automatic clear_pulses();
    {lerr, lsr, iir, rbr, push, thrw, tick} = 7'b0;
  endtask

  // drive one stimulus cycle, one quiet cycle, then check
  task automatic step(input logic [29:0] v);
    en   = v[25:23];
    trig = v[22:21];
    rxc  = v[20:16];
    txc  = v[15:11];
    {lerr, lsr, iir, rbr, push, thrw, tick} = v[10:4];
    @(posedge clk); @(negedge clk);
    clear_pulses();
    @(posedge clk); @(negedge clk);
    check(v[3:0], int'(v[29:26]));
  endtask

  initial begin
    rst_n = 1'b0;
    en = 3'b000; trig = 2'b00; rxc = '0; txc = '0;
    clear_pulses();
    repeat (3) @(negedge clk);
    check(4'b0001, 11); // R11 reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(4'b0001, 11); // R11 after release

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R9: identification read while holding empty is shown clears it
    step({4'd9, 3'b111, 2'b01, 5'd0, 5'd0, 7'b0010000, 4'b0001});
    step({4'd7, 3'b111, 2'b01, 5'd0, 5'd1, 7'b0000010, 4'b0001});
    step({4'd7, 3'b111, 2'b01, 5'd0, 5'd2, 7'b0000010, 4'b0001});
    step({4'd7, 3'b111, 2'b01, 5'd0, 5'd0, 7'b0000000, 4'b0010});
    step({4'd2, 3'b111, 2'b00, 5'd1, 5'd0, 7'b0000100, 4'b0100});
    // R9: read while data is shown leaves holding empty pending
    step({4'd9, 3'b111, 2'b00, 5'd1, 5'd0, 7'b0010000, 4'b0100});
    step({4'd9, 3'b111, 2'b00, 5'd0, 5'd0, 7'b0001000, 4'b0010});

    // R10: error arriving during a read; code frozen, then reported
    lerr = 1'b1; iir = 1'b1;
    @(posedge clk); @(negedge clk);
    clear_pulses();
    check(4'b0010, 10);
    @(posedge clk); @(negedge clk);
    check(4'b0110, 10);
    // R9: that read also cleared holding empty
    step({4'd9, 3'b111, 2'b00, 5'd0, 5'd0, 7'b0100000, 4'b0001});

    // R4: error and status read together keep the error
    step({4'd4, 3'b111, 2'b00, 5'd0, 5'd0, 7'b1100000, 4'b0110});
    step({4'd4, 3'b111, 2'b00, 5'd0, 5'd0, 7'b0100000, 4'b0001});

    // R11: reset in mid-operation
    step({4'd4, 3'b111, 2'b00, 5'd0, 5'd0, 7'b1000000, 4'b0110});
    rst_n = 1'b0;
    #1;
    check(4'b0001, 11);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(4'b0001, 11);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule